// File: doc/BRIEF.md
# SMBus Register Target with Persistent Pointer

This block is a two-wire bus target that serves a small bank of 8-bit registers held outside it. It watches the clock and data lines, recognises one fixed 7-bit device address, and pulls the data line low through an open-drain enable to acknowledge and to return data. It handles four transaction shapes: write byte, read byte (a command write followed by a repeated start and a read), receive byte, and read word.

The first data byte of a write is a command byte, and it loads an internal register pointer. A second data byte writes the register that pointer selects, and later bytes are refused. The pointer is not cleared when a transaction ends. A bare read therefore returns the register chosen by the last command byte, every time it is issued. If the controller acknowledges a returned byte, the same register is sent again instead of the next one.

An `addressed` pulse tells nearby logic that the block has claimed a transfer. The data line is changed only while the clock is low. A device address that does not match leaves the data line released until the next start or stop.

Top module: `smb_reg_target`

## Requirements
- R1: A transfer whose address byte carries the device address in its upper 7 bits (address MSB first, R/W in bit 0) is acknowledged in slot 9. Any other address is not acknowledged, and the data line stays released (reads as 0xFF) until the next START or STOP.
- R2: In a write, the first data byte is acknowledged and loads the pointer (`reg_addr`). The second data byte is acknowledged and produces exactly one one-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R3: The third and later data bytes of a write are not acknowledged and cause no `reg_we` pulse. The register written by the second byte keeps its value.
- R4: After an own-address byte with R/W=1 is acknowledged, the block sends the register selected by the pointer, MSB first. It changes the data line only while SCL is low.
- R5: When the controller acknowledges a returned byte, the next byte is the same register contents again (read word returns two identical bytes).
- R6: The pointer survives STOP. Repeated receive-byte transactions return the same register, and the pointer does not change during a read.
- R7: A controller NACK on a returned byte makes the block release the data line. Further clocked bytes read as 0xFF until STOP or a repeated START.
- R8: A repeated START, arriving at any point including mid-byte, restarts the address phase, and the bit counter begins again.
- R9: `addressed` pulses for exactly one cycle each time the block acknowledges its own address, in either direction, and never for a mismatching address.
- R10: After reset the data line is released, `reg_we` and `addressed` are low, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | PTR_W | Register pointer, selects the register to read or write |
| reg_rdata | input | 8 | Contents of the register selected by `reg_addr` |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| addressed | output | 1 | One-cycle pulse when the own address is acknowledged |

## Verification
The hardest states to reach from the ports are a repeated START that arrives halfway through a data byte and a read that runs on after the controller has NACKed. Neither shape appears in a normal transaction. The bench drives both lines directly through bit-level tasks, so it can stop a byte after four bits and issue a repeated START, and it can keep clocking bytes after a NACK to show that the line stays high. Persistence of the pointer is shown by sweeping every register: each pointer is set once and then read back by several separate receive-byte transactions.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

   localparam int DATA_W    = 8;
   localparam int DEV_BITS  = 7;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_ADDR_ACK,
      S_WR_BYTE,
      S_WR_ACK,
      S_RD_BYTE,
      S_RD_ACK,
      S_IGNORE
   } smbt_state_e;

endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smbt_line_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= din;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/smbt_cond_detect.sv
module smbt_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic cond_start,
   output logic cond_stop
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise   =  scl_s & ~scl_q;
   assign scl_fall   = ~scl_s &  scl_q;
   assign cond_start =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign cond_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
   import smbt_pkg::*;
#(
   parameter logic [DEV_BITS-1:0] DEV_ADDR = 7'h44,
   parameter int                  PTR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              cond_start,
   input  logic              cond_stop,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  ptr,
   output logic [DATA_W-1:0] wdata,
   output logic              we,
   output logic              addressed
);

   localparam int                CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);

   smbt_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx;
   logic [DATA_W-1:0] tx;
   logic              rw;
   logic              mack;
   logic [1:0]        widx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cnt       <= '0;
         rx        <= '0;
         tx        <= '0;
         rw        <= 1'b0;
         mack      <= 1'b0;
         widx      <= '0;
         sda_oe    <= 1'b0;
         ptr       <= '0;
         wdata     <= '0;
         we        <= 1'b0;
         addressed <= 1'b0;
      end else begin
         we        <= 1'b0;
         addressed <= 1'b0;
         if (cond_stop) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
         end else if (cond_start) begin
            state  <= S_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               S_ADDR: begin
                  if (scl_rise) begin
                     rx  <= {rx[DATA_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     if (rx[DATA_W-1:1] == DEV_ADDR) begin
                        rw        <= rx[0];
                        sda_oe    <= 1'b1;
                        addressed <= 1'b1;
                        state     <= S_ADDR_ACK;
                     end else begin
                        state     <= S_IGNORE;
                     end
                  end
               end
               S_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        tx     <= reg_rdata;
                        sda_oe <= ~reg_rdata[DATA_W-1];
                        state  <= S_RD_BYTE;
                     end else begin
                        sda_oe <= 1'b0;
                        widx   <= '0;
                        state  <= S_WR_BYTE;
                     end
                  end
               end
               S_WR_BYTE: begin
                  if (scl_rise) begin
                     rx  <= {rx[DATA_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     if (widx == 2'd0) begin
                        ptr    <= rx[PTR_W-1:0];
                        sda_oe <= 1'b1;
                     end else if (widx == 2'd1) begin
                        wdata  <= rx;
                        we     <= 1'b1;
                        sda_oe <= 1'b1;
                     end else begin
                        sda_oe <= 1'b0;
                     end
                     if (widx != 2'd2) widx <= widx + 1'b1;
                     state <= S_WR_ACK;
                  end
               end
               S_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= S_WR_BYTE;
                  end
               end
               S_RD_BYTE: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == CNT_FULL) begin
                        sda_oe <= 1'b0;
                        state  <= S_RD_ACK;
                     end else begin
                        tx     <= {tx[DATA_W-2:0], 1'b0};
                        sda_oe <= ~tx[DATA_W-2];
                     end
                  end
               end
               S_RD_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        tx     <= reg_rdata;
                        sda_oe <= ~reg_rdata[DATA_W-1];
                        cnt    <= '0;
                        state  <= S_RD_BYTE;
                     end else begin
                        state  <= S_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(cond_stop) && !$past(cond_start)) |-> !$past(scl_s)); // R4

   AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IGNORE) |-> !sda_oe); // R7

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we); // R2

   AST_WE_IN_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (state == S_WR_ACK) && sda_oe); // R3

   AST_ADDRESSED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      addressed |=> !addressed); // R9

   AST_PTR_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RD_BYTE || state == S_RD_ACK) |=> $stable(ptr)); // R6

endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
   import smbt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h44,
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_addr,
   input  logic [7:0]       reg_rdata,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   output logic             addressed
);

   generate
      if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
         $error("PTR_W must lie between 1 and the data width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, cond_start, cond_stop;

   smbt_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (scl_i),
      .dout (scl_s)
   );

   smbt_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sda_i),
      .dout (sda_s)
   );

   smbt_cond_detect u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .cond_start(cond_start),
      .cond_stop (cond_stop)
   );

   smbt_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .cond_start(cond_start),
      .cond_stop (cond_stop),
      .reg_rdata (reg_rdata),
      .sda_oe    (sda_oe),
      .ptr       (reg_addr),
      .wdata     (reg_wdata),
      .we        (reg_we),
      .addressed (addressed)
   );

endmodule

// File: tb/smb_reg_target_test.sv
module smb_reg_target_test;

   localparam logic [6:0] DEV = 7'h44;
   localparam int H = 10;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe, reg_we, addressed;
   logic [7:0] reg_addr, reg_rdata, reg_wdata;
   wire        sda_line = sda_m & ~sda_oe;

   smb_reg_target #(.DEV_ADDR(DEV)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .addressed(addressed)
   );

   logic [7:0] regs [8];
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) regs[i] <= 8'hC0 | 8'(i);
      end else if (reg_we) begin
         regs[reg_addr[2:0]] <= reg_wdata;
      end
   end
   assign reg_rdata = regs[reg_addr[2:0]];

   int errors = 0, checks = 0;
   int we_count = 0, pulse_count = 0;
   logic [7:0] last_wa = '0, last_wd = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (addressed) pulse_count++;
         if (reg_we) begin
            we_count++;
            last_wa = reg_addr;
            last_wd = reg_wdata;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(H);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic send_bit(input bit b);
      sda_m = b; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0;
   endtask

   task automatic wbyte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H / 2);
      ack = ~sda_line;
      tick(H - H / 2);
      scl_m = 1'b0;
   endtask

   task automatic rbyte(input bit m_ack, output logic [7:0] v);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(H);
         scl_m = 1'b1; tick(H / 2);
         v[i] = sda_line;
         tick(H - H / 2);
         scl_m = 1'b0;
      end
      send_bit(!m_ack);
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] pat(input int p);
      return 8'((p * 37 + 11) & 255);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      bit a0, a1, a2;
      logic [7:0] v, v2;
      int wb0, pb0;

      tick(5);
      check(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
      check(reg_we == 1'b0 && addressed == 1'b0, "R10 strobes low", {reg_we, addressed}, 0);
      check(reg_addr == 8'h00, "R10 pointer", reg_addr, 0);
      rst_n = 1'b1;
      tick(5);

      // R2 write sweep over all registers
      for (int p = 0; p < 8; p++) begin
         wb0 = we_count; pb0 = pulse_count;
         bus_start();
         wbyte({DEV, 1'b0}, a0);
         wbyte(8'(p), a1);
         wbyte(pat(p), a2);
         bus_stop();
         check(a0 && a1 && a2, "R1 R2 acks", {a0, a1, a2}, 7);
         check(we_count == wb0 + 1, "R2 one write strobe", we_count - wb0, 1);
         check(last_wa == 8'(p) && last_wd == pat(p), "R2 write addr/data",
               {last_wa, last_wd}, {8'(p), pat(p)});
         check(pulse_count == pb0 + 1, "R9 addressed once", pulse_count - pb0, 1);
      end

      // R4 R8 read byte, then R6 receive byte repeated
      for (int p = 7; p >= 0; p--) begin
         pb0 = pulse_count;
         bus_start();
         wbyte({DEV, 1'b0}, a0);
         wbyte(8'(p), a1);
         bus_rstart();
         wbyte({DEV, 1'b1}, a2);
         rbyte(1'b0, v);
         bus_stop();
         check(v == pat(p), "R4 R8 read byte", v, pat(p));
         check(pulse_count == pb0 + 2, "R9 both directions", pulse_count - pb0, 2);
         for (int k = 0; k < 2; k++) begin
            bus_start();
            wbyte({DEV, 1'b1}, a0);
            rbyte(1'b0, v);
            bus_stop();
            check(a0 && v == pat(p), "R6 receive byte repeat", v, pat(p));
         end
      end

      // R5 read word returns the same register twice
      for (int p = 2; p < 8; p += 3) begin
         bus_start();
         wbyte({DEV, 1'b0}, a0);
         wbyte(8'(p), a1);
         bus_stop();
         bus_start();
         wbyte({DEV, 1'b1}, a0);
         rbyte(1'b1, v);
         rbyte(1'b0, v2);
         bus_stop();
         check(v == pat(p), "R5 first byte", v, pat(p));
         check(v2 == pat(p), "R5 second byte", v2, pat(p));
      end

      // R3 third data byte refused
      wb0 = we_count;
      bus_start();
      wbyte({DEV, 1'b0}, a0);
      wbyte(8'd6, a1);
      wbyte(8'h99, a2);
      check(a0 && a1 && a2, "R3 first two acked", {a0, a1, a2}, 7);
      wbyte(8'h77, a2);
      check(!a2, "R3 third byte nack", a2, 0);
      wbyte(8'h55, a2);
      check(!a2, "R3 fourth byte nack", a2, 0);
      bus_stop();
      check(we_count == wb0 + 1 && last_wd == 8'h99, "R3 single write",
            {8'(we_count - wb0), last_wd}, {8'd1, 8'h99});
      bus_start();
      wbyte({DEV, 1'b1}, a0);
      rbyte(1'b0, v);
      bus_stop();
      check(v == 8'h99, "R3 register kept", v, 8'h99);

      // R1 R9 mismatching address
      pb0 = pulse_count;
      for (int d = 0; d < 7; d++) begin
         bus_start();
         wbyte({DEV ^ 7'(1 << d), 1'b1}, a0);
         check(!a0, "R1 mismatch nack", a0, 0);
         rbyte(1'b1, v);
         check(v == 8'hFF, "R1 line released", v, 8'hFF);
         bus_stop();
      end
      check(pulse_count == pb0, "R9 no pulse on mismatch", pulse_count - pb0, 0);

      // R7 NACK then more clocks
      bus_start();
      wbyte({DEV, 1'b1}, a0);
      rbyte(1'b0, v);
      check(v == 8'h99, "R7 byte before nack", v, 8'h99);
      rbyte(1'b1, v);
      check(v == 8'hFF, "R7 released after nack", v, 8'hFF);
      check(sda_oe == 1'b0, "R7 oe low", sda_oe, 0);
      bus_stop();

      // R8 repeated start in the middle of a data byte
      bus_start();
      wbyte({DEV, 1'b0}, a0);
      for (int i = 0; i < 4; i++) send_bit(i[0]);
      bus_rstart();
      wbyte({DEV, 1'b1}, a1);
      rbyte(1'b0, v);
      bus_stop();
      check(a1, "R8 restart address ack", a1, 1);
      check(v == 8'h99, "R8 pointer unchanged by cut byte", v, 8'h99);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule